// File: doc/BRIEF.md
# Fractional Baud Tick Generator

The block derives a sixteen-times-oversampling strobe for a serial receiver and transmitter from the system clock. The divisor is a whole part plus a fraction in steps of 1/64. Software computes both values from clock / (16 × baud). The whole part is the quotient. The fraction is the remainder scaled by 64 and rounded to nearest. For example, a 100 MHz clock at 115200 baud gives a whole part of 54 and a fraction of 16.

A period counter sets the length of each tick period. A 6-bit accumulator adds the fraction once per tick and adds one extra cycle to a period whenever that addition carries out. The extra cycles are therefore spread evenly, and the average period is exactly whole + fraction/64 cycles. Software loads the divisors while the strobe is disabled, and they take effect on enable. The generator also restarts by itself if either divisor changes while it runs.

Top module: `frac_baud_tick`

## Requirements
- R1: `tick_o` is a single-cycle pulse: when the whole divisor is 2 or more, a high cycle is always followed by a low cycle.
- R2: Each tick period, measured between consecutive high samples of `tick_o`, lasts either I or I+1 cycles, where I is `div_int_i` and F is `div_frac_i`. A period is I+1 exactly when adding F to the 6-bit accumulator value at the start of that period reaches 64 or more. The accumulator starts at 0 and gains F (mod 64) at every tick.
- R3: Starting from enable, the first 64 tick periods together last exactly 64×I + F cycles.
- R4: With F = 0 every period lasts exactly I cycles.
- R5: With I = 0 the generator is idle and `tick_o` stays low while `en_i` is high.
- R6: While `en_i` is low, `tick_o` stays low and the period counter and accumulator return to zero. After `en_i` rises, the first tick appears after the I-th rising edge, counting the first edge that samples `en_i` high as edge 1.
- R7: If either divisor input changes while enabled, the edge that samples the change restarts the generator and produces no tick. The first tick then follows I edges after that edge.
- R8: While `rst_ni` is low, `tick_o` is low.
- R9: With I = 1 and F = 0, `tick_o` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears counter and accumulator |
| div_int_i | input | 16 | Whole part of the divisor, in clock cycles |
| div_frac_i | input | 6 | Fractional part of the divisor, in 1/64 cycle steps |
| tick_o | output | 1 | Oversampling strobe, registered |

## Verification
`tick_o` is registered, so a tick is visible in the cycle after the edge on which the counter reaches the end of its period. The bench counts rising edges from the first edge that samples `en_i` high, or from the edge that samples a divisor change. It samples `tick_o` one nanosecond after each edge, so the first tick is due at edge I. Each later tick is due I or I+1 edges after the previous one, as predicted by a bench-side accumulator model. The bench compares each measured period and the sum over 64 periods against that model. Inputs change only on falling edges.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int unsigned INT_W  = 16;
  localparam int unsigned FRAC_W = 6;
endpackage

// File: rtl/frac_baud_acc.sv
module frac_baud_acc #(
  parameter int unsigned FRAC_W = frac_baud_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              stretch_o
);
  localparam int unsigned SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;

  // carry out of acc + frac marks a long period
  always_comb begin
    sum       = {1'b0, acc_q} + {1'b0, frac_i};
    stretch_o = sum[FRAC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (adv_i) acc_q <= sum[FRAC_W-1:0];
  end

  // R6: a clear leaves no carry pending for the first period
  p_clear_no_stretch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (adv_i || !stretch_o || ($past(frac_i) != frac_i)));
endmodule

// File: rtl/frac_baud_period.sv
module frac_baud_period #(
  parameter int unsigned INT_W = frac_baud_pkg::INT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [INT_W-1:0] int_i,
  input  logic             stretch_i,
  output logic             wrap_o
);
  localparam int unsigned LAST_W = INT_W + 1;

  logic [INT_W-1:0]  cnt_q;
  logic [LAST_W-1:0] last;

  always_comb begin
    last   = {1'b0, int_i} - LAST_W'(1) + LAST_W'(stretch_i);
    wrap_o = run_i && ({1'b0, cnt_q} == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + INT_W'(1);
  end

  // R2: count never runs past the end of the current period
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ({1'b0, cnt_q} <= last));
endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick #(
  parameter int unsigned INT_W  = frac_baud_pkg::INT_W,
  parameter int unsigned FRAC_W = frac_baud_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              tick_o
);
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              chg, run, wrap, stretch, tick_q;

  always_comb begin
    chg = (div_int_i != int_q) || (div_frac_i != frac_q);
    run = en_i && (div_int_i != '0) && !chg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= '0;
      frac_q <= '0;
      tick_q <= 1'b0;
    end else begin
      int_q  <= div_int_i;
      frac_q <= div_frac_i;
      tick_q <= wrap;
    end
  end

  frac_baud_period #(.INT_W(INT_W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .int_i    (div_int_i),
    .stretch_i(stretch),
    .wrap_o   (wrap)
  );

  frac_baud_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!run),
    .adv_i    (wrap),
    .frac_i   (div_frac_i),
    .stretch_o(stretch)
  );

  assign tick_o = tick_q;

  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_int_i == '0) |=> !tick_o);
  p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && chg) |=> !tick_o);
  p_single_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_int_i > INT_W'(1)) |=> !tick_o);
endmodule

// File: tb/frac_baud_tick_bench.sv
`timescale 1ns/1ps
module frac_baud_tick_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic        tick;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  frac_baud_tick u_frac_baud_tick (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .div_int_i (div_int),
    .div_frac_i(div_frac),
    .tick_o    (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // Enable from a cleared state, measure n periods against the accumulator model
  task automatic run_seq(input int i_div, input int f_div, input int n, input string req);
    int e = 0, last = 0, k = 0, acc = 0, sum = 0, per, exp;
    @(negedge clk); en = 1'b0; div_int = 16'(i_div); div_frac = 6'(f_div);
    repeat (3) @(negedge clk);
    en = 1'b1;
    while (k < n && e <= n * (i_div + 1) + 10) begin
      @(posedge clk); #1; e++;
      if (tick) begin
        per  = e - last;
        exp  = i_div + (((acc + f_div) >= 64) ? 1 : 0);
        acc  = (acc + f_div) % 64;
        check(per == exp, req, per, exp);
        sum += per; last = e; k++;
      end
    end
    check(k == n, {req, " tick count"}, k, n);
    if (n == 64) check(sum == 64 * i_div + f_div, "R3 sum of 64 periods", sum, 64 * i_div + f_div);
    @(negedge clk); en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R8 tick low in reset", tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R8 tick low after reset", tick, 0);
  endtask

  task automatic t_main();   run_seq(54, 16, 64, "R2 54+16/64"); endtask
  task automatic t_nofrac(); run_seq(5, 0, 20, "R4 integer only"); endtask
  task automatic t_maxfrac(); run_seq(3, 63, 64, "R1/R2 3+63/64"); endtask
  task automatic t_min();    run_seq(1, 0, 10, "R9 every cycle"); endtask

  task automatic t_zero();
    int cnt = 0;
    @(negedge clk); div_int = 16'd0; div_frac = 6'd10; en = 1'b1;
    repeat (200) begin @(posedge clk); #1; if (tick) cnt++; end
    check(cnt == 0, "R5 idle at zero divisor", cnt, 0);
    @(negedge clk); en = 1'b0;
  endtask

  task automatic t_disable();
    int cnt = 0;
    @(negedge clk); div_int = 16'd6; div_frac = 6'd40;
    @(negedge clk); en = 1'b1;
    repeat (15) @(negedge clk);
    en = 1'b0;
    repeat (50) begin @(posedge clk); #1; if (tick) cnt++; end
    check(cnt == 0, "R6 quiet while disabled", cnt, 0);
    run_seq(6, 40, 8, "R6 fresh start after re-enable");
  endtask

  task automatic t_change();
    int e = 0, first = -1;
    @(negedge clk); div_int = 16'd10; div_frac = 6'd0;
    @(negedge clk); en = 1'b1;
    repeat (25) @(negedge clk);
    div_int = 16'd7;
    @(posedge clk); #1;
    check(tick == 1'b0, "R7 no tick on change edge", tick, 0);
    while (first < 0 && e < 40) begin
      @(posedge clk); #1; e++;
      if (tick) first = e;
    end
    check(first == 7, "R7 first tick after change", first, 7);
    @(negedge clk); en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_main();
    t_nofrac();
    t_maxfrac();
    t_min();
    t_zero();
    t_disable();
    t_change();
    finish_run();
  end
endmodule